// File: doc/BRIEF.md
# Supply Voltage Monitor Filter

This block qualifies the outputs of two supply-voltage comparators before they reach the chip's reset logic. One input flag says the supply is at or below a lower (falling) trip level. The other says the supply is above a higher (rising) trip level. The block counts consecutive clock cycles spent low and issues a registered reset request only once that run is long enough. Shorter runs are treated as supply noise. Once a reset is active, a single cycle above the higher trip level clears it. A supply that sits between the two levels keeps the request in its current state, which gives the filter hysteresis.

Two configuration inputs control the block. `cfg_enable` switches the whole monitor on or off. `cfg_rst_enable` decides whether a qualified low run raises a reset request, or whether software only polls the condition. Polling reads the top bit of a byte-wide, read-only status register on a simple combinational read bus.

Top module: `supply_monitor_filter`

## Requirements
- R1: While `cfg_enable` is 0, `rst_req` is 0 after the next clock edge, and the status bit reads 0 whatever `sup_low` is.
- R2: While `cfg_enable` is 1 and `cfg_rst_enable` is 0, `rst_req` is 0 after the next clock edge. The status bit still follows `sup_low`.
- R3: With both configuration bits at 1, `rst_req` rises on the clock edge that samples the ninth consecutive cycle with `sup_low` at 1 (TRIP_CYCLES = 9). It does not rise on any earlier edge.
- R4: A run of fewer than nine sampled low cycles never raises `rst_req`. Any sampled cycle with `sup_low` at 0 restarts the count from zero.
- R5: While `rst_req` is 1, one clock edge that samples `sup_high` at 1 clears `rst_req` on that same edge.
- R6: While `rst_req` is 1 and both configuration bits are 1, cycles with both `sup_low` and `sup_high` at 0 leave `rst_req` at 1. Cycles with `sup_low` at 1 also leave it at 1.
- R7: When `rd_en` is 1 and `rd_addr` equals STATUS_ADDR (default 4'hF), `rd_data` bit 7 equals `cfg_enable & sup_low` in the same cycle. Bits 6 to 0 read 0. Any other read returns 8'h00.
- R8: The run counter saturates. However long `sup_low` stays at 1, `rst_req` stays at 1 with both configuration bits set, and the counter never exceeds nine.
- R9: A clock edge that samples `rst_n` at 0 clears `rst_req` and the run count. After `rst_n` returns to 1, a fresh run of nine low cycles is needed before the next request.
- R10: `rst_req` is a register output. It changes only on a rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cfg_enable | input | 1 | Enables the monitor |
| cfg_rst_enable | input | 1 | Lets a qualified low run raise a reset request |
| sup_low | input | 1 | Supply at or below the falling trip level |
| sup_high | input | 1 | Supply above the rising trip level |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data; status flag in bit 7 |
| rst_req | output | 1 | Registered reset request |

## Verification
The low-run length is swept from 0 to 12 cycles under all four combinations of the two configuration bits. This separates an early trigger from a late one, and a gated request from an ungated one. After each run, the supply is held between the two trip levels, and then raised above the upper level for exactly one cycle. This separates holding the request from releasing it too early or not at all. Further patterns cover these cases:
- an eight-cycle run broken by one mid-band cycle, which shows whether the count restarts;
- a run of several hundred cycles, which would expose a counter that wraps;
- a power-on reset applied in the middle of a run;
- reads at a non-matching address.

// File: rtl/svm_pkg.sv
package svm_pkg;
  // Saturating increment used by the run counter.
  function automatic int unsigned sat_step(input int unsigned cur, input int unsigned limit);
    return (cur >= limit) ? limit : cur + 1;
  endfunction

  // True when the next count of a low run reaches the trip length.
  function automatic logic run_reaches(input int unsigned cur, input int unsigned limit);
    return sat_step(cur, limit) >= limit;
  endfunction
endpackage

// File: rtl/svm_run_counter.sv
module svm_run_counter #(
  parameter int unsigned TRIP_CYCLES = 9,
  parameter int unsigned CNT_W       = $clog2(TRIP_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             low_seen,
  output logic [CNT_W-1:0] run_cnt,
  output logic             trip_hit
);
  import svm_pkg::*;

  assign trip_hit = low_seen && run_reaches(32'(run_cnt), TRIP_CYCLES);

  always_ff @(posedge clk) begin
    if (!rst_n)         run_cnt <= '0;
    else if (!low_seen) run_cnt <= '0;
    else                run_cnt <= CNT_W'(sat_step(32'(run_cnt), TRIP_CYCLES));
  end
endmodule

// File: rtl/svm_reset_latch.sv
module svm_reset_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic trip_hit,
  input  logic recover,
  output logic rst_req
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 rst_req <= 1'b0;
    else if (!armed)            rst_req <= 1'b0;
    else if (rst_req && recover) rst_req <= 1'b0;
    else if (trip_hit)          rst_req <= 1'b1;
  end
endmodule

// File: rtl/svm_status_port.sv
module svm_status_port #(
  parameter int unsigned        DATA_W      = 8,
  parameter int unsigned        ADDR_W      = 4,
  parameter logic [ADDR_W-1:0]  STATUS_ADDR = '1,
  parameter int unsigned        STATUS_BIT  = DATA_W - 1
) (
  input  logic              flag,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic hit;
  assign hit = rd_en && (rd_addr == STATUS_ADDR);

  always_comb begin
    rd_data = '0;
    if (hit) rd_data[STATUS_BIT] = flag;
  end
endmodule

// File: rtl/supply_monitor_filter.sv
module supply_monitor_filter #(
  parameter int unsigned       TRIP_CYCLES = 9,
  parameter int unsigned       DATA_W      = 8,
  parameter int unsigned       ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 4'hF,
  localparam int unsigned      CNT_W       = $clog2(TRIP_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_rst_enable,
  input  logic              sup_low,
  input  logic              sup_high,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req
);
  // Named internal events for the checker.
  logic             low_seen;
  logic             armed;
  logic             trip_hit;
  logic [CNT_W-1:0] run_cnt;

  assign low_seen = cfg_enable && sup_low;
  assign armed    = cfg_enable && cfg_rst_enable;

  svm_run_counter #(.TRIP_CYCLES(TRIP_CYCLES), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .low_seen(low_seen),
    .run_cnt(run_cnt), .trip_hit(trip_hit)
  );

  svm_reset_latch u_latch (
    .clk(clk), .rst_n(rst_n), .armed(armed), .trip_hit(trip_hit),
    .recover(sup_high), .rst_req(rst_req)
  );

  svm_status_port #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .STATUS_BIT(DATA_W - 1)
  ) u_stat (
    .flag(low_seen), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/svm_checker.sv
module svm_checker #(
  parameter int unsigned TRIP_CYCLES = 9,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned DATA_W      = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              cfg_rst_enable,
  input logic              sup_low,
  input logic              sup_high,
  input logic [DATA_W-1:0] rd_data,
  input logic              rst_req,
  input logic [CNT_W-1:0]  run_cnt
);
  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !rst_req);
  assert_status_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> rd_data == '0);
  assert_poll_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rst_enable |=> !rst_req);
  assert_trip_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(run_cnt) >= CNT_W'(TRIP_CYCLES - 1)) && $past(sup_low));
  assert_run_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_low |=> run_cnt == '0);
  assert_fast_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req && sup_high |=> !rst_req);
  assert_hold_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req && !sup_high && cfg_enable && cfg_rst_enable |=> rst_req);
  assert_low_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-2:0] == '0);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_W'(TRIP_CYCLES));
endmodule

bind supply_monitor_filter svm_checker #(
  .TRIP_CYCLES(TRIP_CYCLES), .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_rst_enable(cfg_rst_enable),
  .sup_low(sup_low), .sup_high(sup_high), .rd_data(rd_data), .rst_req(rst_req),
  .run_cnt(run_cnt)
);

// File: tb/tb_supply_monitor_filter.sv
module tb_supply_monitor_filter;
  localparam int TRIP = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b0, cfg_rst_enable = 1'b0;
  logic       sup_low = 1'b0, sup_high = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_addr = 4'hF;
  logic [7:0] rd_data;
  logic       rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  supply_monitor_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_rst_enable(cfg_rst_enable),
    .sup_low(sup_low), .sup_high(sup_high), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive levels at the falling edge, pass one rising edge, return at the next falling edge.
  task automatic step(input logic lo, input logic hi);
    sup_low = lo; sup_high = hi;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_status(input string req, input logic en, input logic lo);
    rd_en = 1'b1; rd_addr = 4'hF; #1;
    check(req, rd_data, {en & lo, 7'b0});
    rd_addr = 4'h3; #1;
    check("R7", rd_data, 8'h00);
    rd_addr = 4'hF; rd_en = 1'b0; #1;
    check("R7", rd_data, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); step(1'b0, 1'b0); step(1'b0, 1'b0);
    check("R9", {7'b0, rst_req}, 8'h00);
    rst_n = 1'b1;

    // Sweep: enable x reset-enable x run length.
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int n = 0; n <= 12; n++) begin
        logic en, ren, exp;
        en = cfg[1]; ren = cfg[0];
        cfg_enable = en; cfg_rst_enable = ren;
        step(1'b0, 1'b1); step(1'b0, 1'b1);
        check("R1", {7'b0, rst_req}, 8'h00);
        for (int k = 1; k <= n; k++) begin
          sup_low = 1'b1; sup_high = 1'b0;
          check_status(en ? "R2" : "R1", en, 1'b1);
          step(1'b1, 1'b0);
          exp = en && ren && (k >= TRIP);
          check(k == TRIP ? "R3" : (k < TRIP ? "R4" : "R8"), {7'b0, rst_req}, {7'b0, exp});
        end
        exp = en && ren && (n >= TRIP);
        for (int m = 0; m < 3; m++) begin
          step(1'b0, 1'b0);
          check("R6", {7'b0, rst_req}, {7'b0, exp});
        end
        check_status("R7", en, 1'b0);
        step(1'b0, 1'b1);
        check("R5", {7'b0, rst_req}, 8'h00);
      end
    end

    cfg_enable = 1'b1; cfg_rst_enable = 1'b1;
    // Broken run: 8 low, one mid-band cycle, 8 low.
    repeat (8) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    repeat (8) step(1'b1, 1'b0);
    check("R4", {7'b0, rst_req}, 8'h00);
    step(1'b1, 1'b0);
    check("R3", {7'b0, rst_req}, 8'h01);
    step(1'b0, 1'b1);

    // Long run: the count must not wrap.
    for (int k = 1; k <= 300; k++) begin
      step(1'b1, 1'b0);
      if (k >= TRIP && rst_req !== 1'b1) check("R8", {7'b0, rst_req}, 8'h01);
    end
    check("R8", {7'b0, rst_req}, 8'h01);

    // Drop reset-enable while asserted.
    cfg_rst_enable = 1'b0; step(1'b1, 1'b0);
    check("R2", {7'b0, rst_req}, 8'h00);
    cfg_rst_enable = 1'b1; step(1'b0, 1'b1);

    // R10: the output holds between edges after a qualifying input.
    repeat (8) step(1'b1, 1'b0);
    sup_low = 1'b1; @(posedge clk); #1;
    check("R10", {7'b0, rst_req}, 8'h01);
    sup_low = 1'b0; sup_high = 1'b1; #3;
    check("R10", {7'b0, rst_req}, 8'h01);
    @(negedge clk); step(1'b0, 1'b1);

    // Power-on reset in the middle of a run clears the count.
    repeat (5) step(1'b1, 1'b0);
    rst_n = 1'b0; step(1'b1, 1'b0); rst_n = 1'b1;
    repeat (8) step(1'b1, 1'b0);
    check("R9", {7'b0, rst_req}, 8'h00);
    step(1'b1, 1'b0);
    check("R9", {7'b0, rst_req}, 8'h01);
    rst_n = 1'b0; step(1'b1, 1'b0);
    check("R9", {7'b0, rst_req}, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule